// File: doc/BRIEF.md
# I2C Clock Phase Timing Generator

This block times the clock line of an I2C master. On a fixed reference clock it steps through a START lead-in, alternating SCL low and high phases, and a bus-free wait after a STOP. Along the way it emits a one-cycle strobe at which the byte sequencer should change SDA and another at which it should sample SDA. Phase lengths and strobe positions come from three timing words held in the block. Their reset values give standard-mode 100 kHz timing from a 24 MHz reference. The hardware adds a fixed number of cycles to the programmed low and high counts.

The byte sequencer above it requests a START, watches the phase-done pulses to move its bit pointer, and raises the stop request during the last high phase of a transfer. A hold-low input stretches the current low phase while the sequencer has no data ready. Computing the timing values and driving the open-drain pads are left to other blocks.

Top module: `scl_phase_gen`

## Requirements
- R1: Out of reset SCL is high, `idle_o` is high, and no strobe or done pulse is active. The timing words reset to the 100 kHz values for a 24 MHz reference: high count 103, receive offset 41, low count 128, transmit offset 48, lead-in 113, bus-free 113. With these values a low phase lasts 130 cycles and a high phase lasts 110 cycles.
- R2: A write with `wr_sel_i`=0 loads the high count from data bits 25:16 and the receive offset from bits 9:0. Select 1 loads the low count from bits 25:16 and the transmit offset from bits 9:0. Select 2 loads the bus-free count from bits 31:16 and the lead-in count from bits 15:0. Select 3 and all other data bits have no effect.
- R3: Each low phase holds SCL low for the low count plus 2 cycles.
- R4: Each high phase holds SCL high for the high count plus 7 cycles.
- R5: `tx_stb_o` pulses for one cycle in every low phase, at the cycle whose zero-based index within the phase equals the transmit offset. An offset at or beyond the phase length never fires.
- R6: `rx_stb_o` pulses for one cycle in every high phase, at the cycle whose zero-based index equals the receive offset. An offset at or beyond the phase length never fires.
- R7: When idle, a start request begins a lead-in with SCL high for max(lead-in,1) cycles. `start_done_o` pulses on the last of these cycles, and the first low phase follows.
- R8: `low_done_o` pulses on the last cycle of each low phase and `high_done_o` on the last cycle of each high phase.
- R9: If `stop_i` is high on the last cycle of a high phase, SCL stays high for max(bus-free,1) cycles with `idle_o` low, then the block returns to idle. Otherwise another low phase begins.
- R10: A start request made while the block is not idle, including during the bus-free wait, has no effect and is not remembered.
- R11: While `hold_i` is high in a low phase, SCL stays low, the low-phase counter is cleared, and the transmit strobe and `low_done_o` are suppressed. The phase then ends low count + 1 cycles after the last held cycle, and the transmit strobe fires transmit-offset cycles after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Timing word write enable |
| wr_sel_i | input | 2 | Timing word select |
| wr_data_i | input | 32 | Timing word write data |
| start_i | input | 1 | START request, accepted only when idle |
| stop_i | input | 1 | End the transfer after the current high phase |
| hold_i | input | 1 | Stretch: keep SCL low |
| scl_o | output | 1 | SCL level |
| rx_stb_o | output | 1 | Sample SDA strobe |
| tx_stb_o | output | 1 | Change SDA strobe |
| start_done_o | output | 1 | Last cycle of the START lead-in |
| low_done_o | output | 1 | Last cycle of a low phase |
| high_done_o | output | 1 | Last cycle of a high phase |
| idle_o | output | 1 | Ready to accept a START |

## Verification
The bench builds the block with its default parameters: 10-bit phase counts, 16-bit lead-in and bus-free fields, adders of 2 and 7, and stretching enabled. A single run on the reset values covers the full-size 100 kHz timing. All other runs reprogram low counts of 1 to 4 and high counts of 0 to 3, so every transmit offset (including the last in-range one and the first out-of-range one) and several receive offsets can be swept cycle by cycle. These small counts also put zero lead-in and zero bus-free values, stop handling, ignored start requests and stretched low phases of several lengths within a short run.

// File: rtl/scl_tgen_pkg.sv
package scl_tgen_pkg;

   typedef enum logic [2:0] {
      PH_IDLE = 3'd0,
      PH_LEAD = 3'd1,
      PH_LOW  = 3'd2,
      PH_HIGH = 3'd3,
      PH_FREE = 3'd4
   } phase_e;

   localparam logic [1:0] SEL_HIGH = 2'd0;
   localparam logic [1:0] SEL_LOW  = 2'd1;
   localparam logic [1:0] SEL_BUS  = 2'd2;
   localparam int FIELD_LSB = 16;

   // Reference cycles per bus period, kept inside the usable count range
   function automatic int unsigned tg_divider(int unsigned ref_hz, int unsigned bus_hz);
      int unsigned d;
      d = (ref_hz + bus_hz - 1) / bus_hz;
      if (d < 25)   d = 25;
      if (d > 1897) d = 1897;
      return d;
   endfunction

   function automatic bit tg_fast(int unsigned bus_hz);
      return bus_hz > 100000;
   endfunction

   // Total low phase in reference cycles, rounded to nearest
   function automatic int unsigned tg_low_total(int unsigned ref_hz, int unsigned bus_hz);
      int unsigned d;
      d = tg_divider(ref_hz, bus_hz);
      return tg_fast(bus_hz) ? (d * 13 + 9) / 19 : (d * 47 + 43) / 87;
   endfunction

   function automatic int unsigned tg_high_total(int unsigned ref_hz, int unsigned bus_hz);
      int unsigned d;
      d = tg_divider(ref_hz, bus_hz);
      return tg_fast(bus_hz) ? (d * 6 + 9) / 19 : (d * 40 + 43) / 87;
   endfunction

   function automatic int unsigned tg_ns_to_cycles(int unsigned ref_hz, int unsigned ns);
      return (ns * (ref_hz / 1000000) + 999) / 1000;
   endfunction

   function automatic int unsigned tg_lead(int unsigned ref_hz, int unsigned bus_hz);
      return tg_ns_to_cycles(ref_hz, tg_fast(bus_hz) ? 600 : 4700);
   endfunction

   function automatic int unsigned tg_free(int unsigned ref_hz, int unsigned bus_hz);
      return tg_ns_to_cycles(ref_hz, tg_fast(bus_hz) ? 1300 : 4700);
   endfunction

endpackage

// File: rtl/scl_tgen_regs.sv
module scl_tgen_regs #(
   parameter int HL_W     = 10,
   parameter int OFS_W    = 10,
   parameter int LONG_W   = 16,
   parameter int REF_HZ   = 24_000_000,
   parameter int BUS_HZ   = 100_000,
   parameter int LOW_ADD  = 2,
   parameter int HIGH_ADD = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [31:0]       wr_data,
   output logic [HL_W-1:0]   high_cnt,
   output logic [OFS_W-1:0]  rx_ofs,
   output logic [HL_W-1:0]   low_cnt,
   output logic [OFS_W-1:0]  tx_ofs,
   output logic [LONG_W-1:0] lead_cnt,
   output logic [LONG_W-1:0] free_cnt
);
   import scl_tgen_pkg::*;

   localparam int unsigned HI_TOT = tg_high_total(REF_HZ, BUS_HZ);
   localparam int unsigned LO_TOT = tg_low_total(REF_HZ, BUS_HZ);

   localparam logic [HL_W-1:0]   RST_HIGH = HL_W'(HI_TOT - HIGH_ADD);
   localparam logic [HL_W-1:0]   RST_LOW  = HL_W'(LO_TOT - LOW_ADD);
   localparam logic [OFS_W-1:0]  RST_RX   = OFS_W'(HI_TOT * 3 / 8);
   localparam logic [OFS_W-1:0]  RST_TX   = OFS_W'(LO_TOT * 3 / 8);
   localparam logic [LONG_W-1:0] RST_LEAD = LONG_W'(tg_lead(REF_HZ, BUS_HZ));
   localparam logic [LONG_W-1:0] RST_FREE = LONG_W'(tg_free(REF_HZ, BUS_HZ));

   logic wr_high, wr_low, wr_bus;
   assign wr_high = wr_en && (wr_sel == SEL_HIGH);
   assign wr_low  = wr_en && (wr_sel == SEL_LOW);
   assign wr_bus  = wr_en && (wr_sel == SEL_BUS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         high_cnt <= RST_HIGH;
         rx_ofs   <= RST_RX;
      end else if (wr_high) begin
         high_cnt <= wr_data[FIELD_LSB +: HL_W];
         rx_ofs   <= wr_data[OFS_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_cnt <= RST_LOW;
         tx_ofs  <= RST_TX;
      end else if (wr_low) begin
         low_cnt <= wr_data[FIELD_LSB +: HL_W];
         tx_ofs  <= wr_data[OFS_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         free_cnt <= RST_FREE;
         lead_cnt <= RST_LEAD;
      end else if (wr_bus) begin
         free_cnt <= wr_data[FIELD_LSB +: LONG_W];
         lead_cnt <= wr_data[LONG_W-1:0];
      end
   end

endmodule

// File: rtl/scl_tgen_limits.sv
module scl_tgen_limits #(
   parameter int HL_W     = 10,
   parameter int LONG_W   = 16,
   parameter int LOW_ADD  = 2,
   parameter int HIGH_ADD = 7,
   localparam int CNT_W   = LONG_W
) (
   input  scl_tgen_pkg::phase_e phase,
   input  logic [HL_W-1:0]      high_cnt,
   input  logic [HL_W-1:0]      low_cnt,
   input  logic [LONG_W-1:0]    lead_cnt,
   input  logic [LONG_W-1:0]    free_cnt,
   output logic [CNT_W-1:0]     last_idx
);
   import scl_tgen_pkg::*;

   logic [CNT_W-1:0] low_last, high_last, lead_last, free_last;

   // Phase length minus one; zero-length lead-in and bus-free count as one cycle
   assign low_last  = CNT_W'(low_cnt)  + CNT_W'(LOW_ADD - 1);
   assign high_last = CNT_W'(high_cnt) + CNT_W'(HIGH_ADD - 1);
   assign lead_last = (lead_cnt == '0) ? '0 : lead_cnt - 1'b1;
   assign free_last = (free_cnt == '0) ? '0 : free_cnt - 1'b1;

   always_comb begin
      unique case (phase)
         PH_LEAD: last_idx = lead_last;
         PH_LOW:  last_idx = low_last;
         PH_HIGH: last_idx = high_last;
         PH_FREE: last_idx = free_last;
         default: last_idx = '0;
      endcase
   end

endmodule

// File: rtl/scl_tgen_counter.sv
module scl_tgen_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/scl_tgen_fsm.sv
module scl_tgen_fsm (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start_req,
   input  logic                 stop_req,
   input  logic                 hold,
   input  logic                 at_last,
   output scl_tgen_pkg::phase_e phase,
   output logic                 cnt_clr,
   output logic                 cnt_inc
);
   import scl_tgen_pkg::*;

   phase_e nxt;

   always_comb begin
      nxt     = phase;
      cnt_clr = 1'b0;
      cnt_inc = 1'b0;
      unique case (phase)
         PH_IDLE: if (start_req) begin
            nxt     = PH_LEAD;
            cnt_clr = 1'b1;
         end
         PH_LEAD: if (at_last) begin
            nxt     = PH_LOW;
            cnt_clr = 1'b1;
         end else cnt_inc = 1'b1;
         PH_LOW: if (hold) begin
            cnt_clr = 1'b1;
         end else if (at_last) begin
            nxt     = PH_HIGH;
            cnt_clr = 1'b1;
         end else cnt_inc = 1'b1;
         PH_HIGH: if (at_last) begin
            nxt     = stop_req ? PH_FREE : PH_LOW;
            cnt_clr = 1'b1;
         end else cnt_inc = 1'b1;
         PH_FREE: if (at_last) begin
            nxt     = PH_IDLE;
            cnt_clr = 1'b1;
         end else cnt_inc = 1'b1;
         default: begin
            nxt     = PH_IDLE;
            cnt_clr = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= PH_IDLE;
      else        phase <= nxt;
   end

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen #(
   parameter int HL_W       = 10,
   parameter int OFS_W      = 10,
   parameter int LONG_W     = 16,
   parameter int REF_HZ     = 24_000_000,
   parameter int BUS_HZ     = 100_000,
   parameter int LOW_ADD    = 2,
   parameter int HIGH_ADD   = 7,
   parameter bit STRETCH_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en_i,
   input  logic [1:0]  wr_sel_i,
   input  logic [31:0] wr_data_i,
   input  logic        start_i,
   input  logic        stop_i,
   input  logic        hold_i,
   output logic        scl_o,
   output logic        rx_stb_o,
   output logic        tx_stb_o,
   output logic        start_done_o,
   output logic        low_done_o,
   output logic        high_done_o,
   output logic        idle_o
);
   import scl_tgen_pkg::*;

   localparam int CNT_W = LONG_W;

   // Elaboration-time parameter checks
   if (HL_W < 2 || HL_W > 16) begin : g_bad_hl_w
      $error("HL_W must lie in 2..16");
   end
   if (LONG_W > 16 || LONG_W <= HL_W) begin : g_bad_long_w
      $error("LONG_W must exceed HL_W and be at most 16");
   end
   if (OFS_W < 1 || OFS_W > 16 || OFS_W > LONG_W) begin : g_bad_ofs_w
      $error("OFS_W must fit the low half of a word and the counter");
   end
   if (LOW_ADD < 1 || HIGH_ADD < 1) begin : g_bad_add
      $error("fixed phase adders must be at least one cycle");
   end
   if ((1 << HL_W) + HIGH_ADD + LOW_ADD > (1 << LONG_W)) begin : g_bad_range
      $error("counter too narrow for the longest phase");
   end

   logic [HL_W-1:0]   high_cnt, low_cnt;
   logic [OFS_W-1:0]  rx_ofs, tx_ofs;
   logic [LONG_W-1:0] lead_cnt, free_cnt;
   logic [CNT_W-1:0]  cnt, last_idx;
   logic              cnt_clr, cnt_inc, at_last, hold_eff;
   phase_e            phase;
   logic              unused_wr_bits;

   assign unused_wr_bits = ^wr_data_i;

   if (STRETCH_EN) begin : g_stretch
      assign hold_eff = hold_i && (phase == PH_LOW);
   end else begin : g_no_stretch
      assign hold_eff = 1'b0;
   end

   scl_tgen_regs #(
      .HL_W(HL_W), .OFS_W(OFS_W), .LONG_W(LONG_W), .REF_HZ(REF_HZ),
      .BUS_HZ(BUS_HZ), .LOW_ADD(LOW_ADD), .HIGH_ADD(HIGH_ADD)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_sel(wr_sel_i),
      .wr_data(wr_data_i), .high_cnt(high_cnt), .rx_ofs(rx_ofs),
      .low_cnt(low_cnt), .tx_ofs(tx_ofs), .lead_cnt(lead_cnt),
      .free_cnt(free_cnt)
   );

   scl_tgen_limits #(
      .HL_W(HL_W), .LONG_W(LONG_W), .LOW_ADD(LOW_ADD), .HIGH_ADD(HIGH_ADD)
   ) u_limits (
      .phase(phase), .high_cnt(high_cnt), .low_cnt(low_cnt),
      .lead_cnt(lead_cnt), .free_cnt(free_cnt), .last_idx(last_idx)
   );

   scl_tgen_counter #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc), .cnt(cnt)
   );

   assign at_last = (cnt == last_idx);

   scl_tgen_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .start_req(start_i), .stop_req(stop_i),
      .hold(hold_eff), .at_last(at_last), .phase(phase),
      .cnt_clr(cnt_clr), .cnt_inc(cnt_inc)
   );

   logic in_low, in_high;
   assign in_low  = (phase == PH_LOW);
   assign in_high = (phase == PH_HIGH);

   assign scl_o        = !in_low;
   assign tx_stb_o     = in_low && !hold_eff && (cnt == CNT_W'(tx_ofs));
   assign rx_stb_o     = in_high && (cnt == CNT_W'(rx_ofs));
   assign start_done_o = (phase == PH_LEAD) && at_last;
   assign low_done_o   = in_low && !hold_eff && at_last;
   assign high_done_o  = in_high && at_last;
   assign idle_o       = (phase == PH_IDLE);

endmodule

// File: rtl/scl_phase_gen_chk.sv
module scl_phase_gen_chk #(
   parameter bit STRETCH_EN = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic stop_i,
   input logic hold_i,
   input logic scl_o,
   input logic rx_stb_o,
   input logic tx_stb_o,
   input logic start_done_o,
   input logic low_done_o,
   input logic high_done_o,
   input logic idle_o
);
   a_r5_tx_only_low: assert property (@(posedge clk) disable iff (!rst_n)
      tx_stb_o |-> !scl_o);

   a_r6_rx_only_high: assert property (@(posedge clk) disable iff (!rst_n)
      rx_stb_o |-> scl_o);

   a_r7_low_follows_lead: assert property (@(posedge clk) disable iff (!rst_n)
      start_done_o |=> !scl_o);

   a_r8_high_follows_low: assert property (@(posedge clk) disable iff (!rst_n)
      low_done_o |=> scl_o);

   a_r3_rise_after_low_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_o) |-> $past(low_done_o));

   a_r4_fall_after_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scl_o) |-> $past(start_done_o || high_done_o));

   a_r9_free_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      (high_done_o && stop_i) |=> (scl_o && !idle_o));

   a_r10_start_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_o && start_i) |=> (scl_o && !idle_o));

   if (STRETCH_EN) begin : g_hold_chk
      a_r11_hold_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
         (!scl_o && hold_i) |=> !scl_o);
   end
endmodule

bind scl_phase_gen scl_phase_gen_chk #(.STRETCH_EN(STRETCH_EN)) u_chk (
   .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
   .hold_i(hold_i), .scl_o(scl_o), .rx_stb_o(rx_stb_o), .tx_stb_o(tx_stb_o),
   .start_done_o(start_done_o), .low_done_o(low_done_o),
   .high_done_o(high_done_o), .idle_o(idle_o)
);

// File: tb/tb_scl_phase_gen.sv
module tb_scl_phase_gen;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [1:0]  wr_sel_i = 2'd0;
   logic [31:0] wr_data_i = 32'd0;
   logic        start_i = 1'b0;
   logic        stop_i = 1'b0;
   logic        hold_i = 1'b0;
   logic        scl_o, rx_stb_o, tx_stb_o, start_done_o;
   logic        low_done_o, high_done_o, idle_o;

   int vectors = 0;
   int fails   = 0;

   always #10 clk = ~clk;

   scl_phase_gen dut (
      .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i),
      .wr_data_i(wr_data_i), .start_i(start_i), .stop_i(stop_i),
      .hold_i(hold_i), .scl_o(scl_o), .rx_stb_o(rx_stb_o),
      .tx_stb_o(tx_stb_o), .start_done_o(start_done_o),
      .low_done_o(low_done_o), .high_done_o(high_done_o), .idle_o(idle_o)
   );

   task automatic chk(input string tag, input string what, input int t,
                      input logic got, input logic exp);
      vectors++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s at t=%0d: got %0b expected %0b", tag, what, t, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input logic [31:0] d);
      @(negedge clk);
      wr_en_i   = 1'b1;
      wr_sel_i  = sel;
      wr_data_i = d;
      @(negedge clk);
      wr_en_i   = 1'b0;
      wr_data_i = 32'd0;
   endtask

   // One transfer of two bits: lead-in, low/high, low/high, bus-free, idle.
   task automatic run_case(input string tg, input int lead, input int lo,
                           input int hi, input int txo, input int rxo,
                           input int free, input int hold_len,
                           input bit do_wr, input bit junk);
      int L, LO, HI, F, ls0, hs0, ls1, hs1, fs, t0, tx0, tx1, rx0, rx1, tend;
      logic in_low;
      string sc_tag, tx_tag, id_tag;
      if (do_wr) begin
         // R2: fields at 25:16 and 9:0 (bus word 31:16 and 15:0); junk elsewhere
         wr(2'd0, (32'(hi) << 16) | 32'(rxo) | (junk ? 32'hFC00_FC00 : 32'd0));
         wr(2'd1, (32'(lo) << 16) | 32'(txo) | (junk ? 32'hFC00_FC00 : 32'd0));
         wr(2'd2, (32'(free) << 16) | 32'(lead));
         if (junk) wr(2'd3, 32'h0001_0001);
      end
      L   = (lead == 0) ? 1 : lead;
      F   = (free == 0) ? 1 : free;
      LO  = lo + 2;
      HI  = hi + 7;
      t0  = L + 1;
      ls0 = L;
      hs0 = ls0 + ((hold_len > 0) ? (1 + hold_len + LO) : LO);
      ls1 = hs0 + HI;
      hs1 = ls1 + LO;
      fs  = hs1 + HI;
      tend = fs + F + 1;
      tx0 = (txo >= LO) ? -1 : ((hold_len > 0) ? t0 + hold_len + txo : ls0 + txo);
      tx1 = (txo >= LO) ? -1 : ls1 + txo;
      rx0 = (rxo >= HI) ? -1 : hs0 + rxo;
      rx1 = (rxo >= HI) ? -1 : hs1 + rxo;
      tx_tag = (hold_len > 0) ? "R11" : "R5";

      @(negedge clk);
      start_i = 1'b1;
      for (int t = 0; t <= tend; t++) begin
         @(negedge clk);
         in_low = ((t >= ls0) && (t < hs0)) || ((t >= ls1) && (t < hs1));
         if (tg != "") sc_tag = tg;
         else sc_tag = in_low ? "R3" : "R4";
         id_tag = (t >= fs) ? "R10" : "R9";
         chk(sc_tag, "scl", t, scl_o, !in_low);
         chk(tx_tag, "tx_stb", t, tx_stb_o, (t == tx0) || (t == tx1));
         chk("R6", "rx_stb", t, rx_stb_o, (t == rx0) || (t == rx1));
         chk("R7", "start_done", t, start_done_o, t == L - 1);
         chk("R8", "low_done", t, low_done_o, (t == hs0 - 1) || (t == hs1 - 1));
         chk("R8", "high_done", t, high_done_o, (t == ls1 - 1) || (t == fs - 1));
         chk(id_tag, "idle", t, idle_o, t >= fs + F);
         // drive for the next edge
         start_i = (t == ls0) || (t == fs);
         hold_i  = (hold_len > 0) && (t >= t0) && (t < t0 + hold_len);
         stop_i  = (t >= hs1) && (t < fs + F);
      end
      start_i = 1'b0;
      stop_i  = 1'b0;
      hold_i  = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      fails++;
      $display("FAIL R9 watchdog: got timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1", "scl", 0, scl_o, 1'b1);
      chk("R1", "idle", 0, idle_o, 1'b1);
      chk("R1", "tx_stb", 0, tx_stb_o, 1'b0);
      chk("R1", "rx_stb", 0, rx_stb_o, 1'b0);
      chk("R1", "dones", 0, start_done_o | low_done_o | high_done_o, 1'b0);

      // R1: reset timing words, 130-cycle low and 110-cycle high
      run_case("R1", 113, 128, 103, 48, 41, 113, 0, 1'b0, 1'b0);

      // R3 R4 R5 R6 R7 R8 R9 R10: sweep of small counts and offsets
      for (int lo = 1; lo <= 4; lo++) begin
         for (int hi = 0; hi <= 3; hi++) begin
            for (int txo = 0; txo <= lo + 2; txo++) begin
               for (int k = 0; k < 4; k++) begin
                  int rxo;
                  case (k)
                     0: rxo = 0;
                     1: rxo = (hi + 7) * 3 / 8;
                     2: rxo = hi + 6;
                     default: rxo = hi + 7;
                  endcase
                  run_case((txo == 1) ? "R2" : "", (lo + hi) % 3, lo, hi,
                           txo, rxo, (lo * hi) % 3, 0, 1'b1, txo == 1);
               end
            end
         end
      end

      // R11: stretched low phases
      for (int lo = 1; lo <= 3; lo += 2) begin
         for (int h = 1; h <= 4; h += 3) begin
            run_case("R11", 1, lo, 1, 2, 2, 2, h, 1'b1, 1'b0);
         end
      end

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule